// File: doc/BRIEF.md
# Window-Controlled Stepping Keystream Generator

This block produces a binary keystream, one bit per round, from three linear feedback shift registers. A control register A decides, once per round, which of two generating registers (B or C) advances. It also decides how many times that register advances. The step count is one plus the binary value of a small window of register-A bits. The positions of those bits come from programmable index inputs, one index set for each generating register.

A one-hot three-phase sequencer runs each round. In the pick phase it reads the low bit of A, loads a down-counter with the matching step count and advances A once. It then stays in the chosen run phase for as many cycles as the count, advancing only the selected register. Every pick phase after the first one in a run presents a keystream bit with a one-cycle valid strobe. Seeds are loaded through a synchronous load input. An enable input freezes everything without losing state, and a mode input chooses whether A's output bit is mixed into the keystream.

Top module: `kgw_stepgen`

## Requirements
- R1: In a pick cycle, if bit 0 of register A is 1 then register B advances `delta_b` times and C holds; if it is 0 then C advances `delta_c` times and B holds.
- R2: Each step count equals 1 plus the sum over j of `A[idx_j] * 2^j`, where `idx_j` is field j of the index input, found at bits `[j*IW +: IW]` of `win_b` (for B) or `win_c` (for C).
- R3: A round lasts exactly 1 + delta cycles of enable: one pick cycle and then delta run cycles. Register A advances once per round, in the pick cycle, and holds during run cycles.
- R4: The keystream bit is `outA ^ outB ^ outC` when `mix_ctl` is 1, and `outB ^ outC` when it is 0. It is taken in the pick cycle, where a register's output is its bit 0.
- R5: A register that has not advanced since the last load or reset contributes 0 to the keystream, whatever its bit 0 holds.
- R6: `ks_valid` is high for exactly one cycle in each pick cycle with enable high, except for the first pick cycle after a load or reset. It is low in every other cycle.
- R7: While `en` is 0 and `seed_load` is 0, no register, counter or phase changes, and `ks_valid` is low.
- R8: `seed_load` takes priority over `en`. It copies the three seeds into the registers, replaces an all-zero seed by the value 1, and restarts at a first pick cycle.
- R9: After reset, all three registers hold the value 1, the phase is pick, the next pick cycle is a first one, and `ks_valid` is low.
- R10: Advancing a register of length L with tap mask T sets it to `{^(q & T), q[L-1:1]}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the whole generator |
| seed_load | input | 1 | Load the seeds and restart |
| seed_a | input | L_A | Seed of control register A |
| seed_b | input | L_B | Seed of generating register B |
| seed_c | input | L_C | Seed of generating register C |
| win_b | input | W*IW | Index fields choosing A bits for B's step count |
| win_c | input | W*IW | Index fields choosing A bits for C's step count |
| mix_ctl | input | 1 | 1: include A's output bit in the keystream |
| ks_bit | output | 1 | Keystream bit, meaningful while ks_valid is high |
| ks_valid | output | 1 | One-cycle strobe marking a new keystream bit |

## Verification
The bench builds the block with register lengths 8, 7 and 5 and a two-bit window, so the index width is 3. Every index value then names a real bit of A, and all four step counts from 1 to 4 occur within a few rounds. These short registers keep each round under six cycles. A bench-side model of the round rules can therefore follow dozens of rounds over several seeds, index choices and both mixing modes. The configurations include zero seeds, repeated indices and a first bit that relies on an unadvanced register.

// File: rtl/kgw_pkg.sv
`timescale 1ns/1ps
package kgw_pkg;
  // One-hot round phases: pick, run register B, run register C.
  typedef enum logic [2:0] {
    PH_PICK  = 3'b100,
    PH_RUN_B = 3'b010,
    PH_RUN_C = 3'b001
  } phase_t;
endpackage

// File: rtl/kgw_lfsr.sv
`timescale 1ns/1ps
module kgw_lfsr #(
  parameter int            LEN  = 8,
  parameter logic [LEN-1:0] TAPS = {{(LEN-1){1'b0}}, 1'b1}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] seed,
  input  logic           adv,
  output logic [LEN-1:0] state_o,
  output logic           moved_o
);
  localparam logic [LEN-1:0] ONE = {{(LEN-1){1'b0}}, 1'b1};

  logic [LEN-1:0] q, q_n;
  logic           moved, moved_n;
  logic           fb;

  always_comb begin
    fb      = ^(q & TAPS);
    q_n     = q;
    moved_n = moved;
    if (load) begin
      q_n     = (seed == '0) ? ONE : seed;
      moved_n = 1'b0;
    end else if (adv) begin
      q_n     = {fb, q[LEN-1:1]};
      moved_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= ONE;
      moved <= 1'b0;
    end else begin
      q     <= q_n;
      moved <= moved_n;
    end
  end

  assign state_o = q;
  assign moved_o = moved;

  AST_LFSR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(q)); // R7
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0); // R8
endmodule

// File: rtl/kgw_window.sv
`timescale 1ns/1ps
module kgw_window #(
  parameter int LEN = 8,
  parameter int W   = 2,
  parameter int IW  = 3
) (
  input  logic [LEN-1:0]  src,
  input  logic [W*IW-1:0] idx,
  output logic [W:0]      count
);
  logic [W-1:0] picked;

  for (genvar j = 0; j < W; j++) begin : g_bit
    logic [LEN-1:0] hot;
    always_comb begin
      for (int k = 0; k < LEN; k++) begin
        hot[k] = (idx[j*IW +: IW] == IW'(k));
      end
    end
    assign picked[j] = |(hot & src);
  end

  assign count = {1'b0, picked} + (W+1)'(1);
endmodule

// File: rtl/kgw_ctrl.sv
`timescale 1ns/1ps
module kgw_ctrl #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          sel,
  input  logic [CW-1:0] cnt_b,
  input  logic [CW-1:0] cnt_c,
  output logic          adv_a,
  output logic          adv_b,
  output logic          adv_c,
  output logic          at_pick,
  output logic          fresh
);
  import kgw_pkg::*;

  phase_t        ph, ph_n;
  logic [CW-1:0] left, left_n;
  logic          fresh_q, fresh_n;

  always_comb begin
    ph_n    = ph;
    left_n  = left;
    fresh_n = fresh_q;
    if (load) begin
      ph_n    = PH_PICK;
      left_n  = '0;
      fresh_n = 1'b1;
    end else if (en) begin
      unique case (ph)
        PH_PICK: begin
          left_n  = sel ? cnt_b : cnt_c;
          ph_n    = sel ? PH_RUN_B : PH_RUN_C;
          fresh_n = 1'b0;
        end
        PH_RUN_B, PH_RUN_C: begin
          left_n = left - CW'(1);
          if (left == CW'(1)) ph_n = PH_PICK;
        end
        default: ph_n = PH_PICK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_PICK;
      left    <= '0;
      fresh_q <= 1'b1;
    end else begin
      ph      <= ph_n;
      left    <= left_n;
      fresh_q <= fresh_n;
    end
  end

  assign adv_a   = en && !load && (ph == PH_PICK);
  assign adv_b   = en && !load && (ph == PH_RUN_B);
  assign adv_c   = en && !load && (ph == PH_RUN_C);
  assign at_pick = (ph == PH_PICK);
  assign fresh   = fresh_q;

  AST_PHASE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ph) == 1); // R3
  AST_RUN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_PICK) |-> (left != '0)); // R3
  AST_PICK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && ph == PH_PICK) |=> (ph != PH_PICK)); // R3
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(ph) && $stable(left) && $stable(fresh_q))); // R7
endmodule

// File: rtl/kgw_stepgen.sv
`timescale 1ns/1ps
module kgw_stepgen #(
  parameter int              L_A   = 64,
  parameter int              L_B   = 61,
  parameter int              L_C   = 59,
  parameter int              W     = 2,
  parameter logic [L_A-1:0]  TAP_A = 64'hB000_0000_0000_0001,
  parameter logic [L_B-1:0]  TAP_B = 61'h1000_6000_0000_0001,
  parameter logic [L_C-1:0]  TAP_C = 59'h0400_0060_0000_0001,
  localparam int             IW    = (L_A > 1) ? $clog2(L_A) : 1,
  localparam int             CW    = W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            seed_load,
  input  logic [L_A-1:0]  seed_a,
  input  logic [L_B-1:0]  seed_b,
  input  logic [L_C-1:0]  seed_c,
  input  logic [W*IW-1:0] win_b,
  input  logic [W*IW-1:0] win_c,
  input  logic            mix_ctl,
  output logic            ks_bit,
  output logic            ks_valid
);
  logic [L_A-1:0] r_a;
  logic [L_B-1:0] r_b;
  logic [L_C-1:0] r_c;
  logic           mv_a, mv_b, mv_c;
  logic           adv_a, adv_b, adv_c;
  logic           at_pick, fresh;
  logic [CW-1:0]  cnt_b, cnt_c;

  kgw_lfsr #(.LEN(L_A), .TAPS(TAP_A)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_a),
    .adv(adv_a), .state_o(r_a), .moved_o(mv_a));
  kgw_lfsr #(.LEN(L_B), .TAPS(TAP_B)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_b),
    .adv(adv_b), .state_o(r_b), .moved_o(mv_b));
  kgw_lfsr #(.LEN(L_C), .TAPS(TAP_C)) u_reg_c (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_c),
    .adv(adv_c), .state_o(r_c), .moved_o(mv_c));

  kgw_window #(.LEN(L_A), .W(W), .IW(IW)) u_win_b (
    .src(r_a), .idx(win_b), .count(cnt_b));
  kgw_window #(.LEN(L_A), .W(W), .IW(IW)) u_win_c (
    .src(r_a), .idx(win_c), .count(cnt_c));

  kgw_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .load(seed_load), .sel(r_a[0]),
    .cnt_b(cnt_b), .cnt_c(cnt_c), .adv_a(adv_a), .adv_b(adv_b),
    .adv_c(adv_c), .at_pick(at_pick), .fresh(fresh));

  // Unadvanced registers contribute zero.
  assign ks_bit   = (mix_ctl & mv_a & r_a[0]) ^ (mv_b & r_b[0]) ^ (mv_c & r_c[0]);
  assign ks_valid = en && !seed_load && at_pick && !fresh;

  AST_B_CHOSEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seed_load && at_pick && r_a[0]) |=> !adv_c); // R1
  AST_C_CHOSEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seed_load && at_pick && !r_a[0]) |=> !adv_b); // R1
  AST_B_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_c && !seed_load) |=> $stable(r_b)); // R1
  AST_C_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_b && !seed_load) |=> $stable(r_c)); // R1
  AST_A_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_pick && !seed_load) |=> $stable(r_a)); // R3
endmodule

// File: tb/sim_kgw_stepgen.sv
`timescale 1ns/1ps
module sim_kgw_stepgen;
  localparam int LA = 8, LB = 7, LC = 5, WW = 2, IWB = 3;
  localparam logic [LA-1:0] TA = 8'h71;
  localparam logic [LB-1:0] TB = 7'h41;
  localparam logic [LC-1:0] TC = 5'h09;

  // {seed_a, seed_b, seed_c, win_b, win_c, mix_ctl}
  localparam int NV = 5;
  localparam logic [32:0] VEC [NV] = '{
    {8'h03, 7'h55, 5'h01, {3'd3, 3'd1}, {3'd7, 3'd0}, 1'b0},  // R5: C unadvanced at first bit
    {8'hA6, 7'h12, 5'h1F, {3'd7, 3'd6}, {3'd2, 3'd5}, 1'b1},
    {8'h00, 7'h00, 5'h00, {3'd1, 3'd2}, {3'd4, 3'd3}, 1'b1},  // R8: zero seeds
    {8'hFF, 7'h7F, 5'h10, {3'd0, 3'd0}, {3'd0, 3'd0}, 1'b0},
    {8'h5A, 7'h33, 5'h0C, {3'd4, 3'd4}, {3'd1, 3'd6}, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, en, seed_load, mix_ctl;
  logic [LA-1:0] seed_a;
  logic [LB-1:0] seed_b;
  logic [LC-1:0] seed_c;
  logic [WW*IWB-1:0] win_b, win_c;
  logic ks_bit, ks_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [LA-1:0] ma;
  logic [LB-1:0] mb;
  logic [LC-1:0] mc;
  bit mva, mvb, mvc;

  always #10 clk = ~clk;

  kgw_stepgen #(.L_A(LA), .L_B(LB), .L_C(LC), .W(WW),
                .TAP_A(TA), .TAP_B(TB), .TAP_C(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
    .seed_a(seed_a), .seed_b(seed_b), .seed_c(seed_c),
    .win_b(win_b), .win_c(win_c), .mix_ctl(mix_ctl),
    .ks_bit(ks_bit), .ks_valid(ks_valid));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int win_val(input logic [WW*IWB-1:0] idx);
    int v = 0;
    for (int j = 0; j < WW; j++) v += int'(ma[idx[j*IWB +: IWB]]) << j;
    return v + 1;
  endfunction

  function automatic logic exp_bit();
    return (mix_ctl & mva & ma[0]) ^ (mvb & mb[0]) ^ (mvc & mc[0]);
  endfunction

  // One round by the requirements; returns cycles until the next pick.
  task automatic model_round(output int gap);
    int d;
    if (ma[0]) begin
      d = win_val(win_b);
      for (int k = 0; k < d; k++) mb = {^(mb & TB), mb[LB-1:1]};
      mvb = 1'b1;
    end else begin
      d = win_val(win_c);
      for (int k = 0; k < d; k++) mc = {^(mc & TC), mc[LC-1:1]};
      mvc = 1'b1;
    end
    ma  = {^(ma & TA), ma[LA-1:1]};
    mva = 1'b1;
    gap = 1 + d;
  endtask

  task automatic model_seed(input logic [LA-1:0] a, input logic [LB-1:0] b,
                            input logic [LC-1:0] c);
    ma = (a == '0) ? LA'(1) : a;
    mb = (b == '0) ? LB'(1) : b;
    mc = (c == '0) ? LC'(1) : c;
    mva = 1'b0; mvb = 1'b0; mvc = 1'b0;
  endtask

  // Caller stands at a negedge with the design in a first pick cycle.
  task automatic run_rounds(input int n, input bit stall);
    int g;
    logic eb;
    chk(ks_valid == 1'b0, "R6 no strobe on first pick", int'(ks_valid), 0);
    model_round(g);
    for (int r = 0; r < n; r++) begin
      eb = exp_bit();
      for (int i = 1; i <= g; i++) begin
        @(negedge clk);
        if (i < g) begin
          chk(ks_valid == 1'b0, "R3 R6 strobe inside round", int'(ks_valid), 0);
          if (stall && r == 1 && i == 1) begin
            en = 1'b0;
            repeat (3) begin
              @(negedge clk);
              chk(ks_valid == 1'b0, "R7 strobe while stalled", int'(ks_valid), 0);
            end
            en = 1'b1;
          end
        end else begin
          chk(ks_valid == 1'b1, "R3 R6 strobe at round end", int'(ks_valid), 1);
          chk(ks_bit == eb, "R1 R2 R4 R5 R10 keystream bit", int'(ks_bit), int'(eb));
        end
      end
      model_round(g);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; seed_load = 1'b0; mix_ctl = 1'b1;
    seed_a = '0; seed_b = '0; seed_c = '0;
    win_b = {3'd5, 3'd2}; win_c = {3'd1, 3'd7};
    repeat (3) @(negedge clk);
    chk(ks_valid == 1'b0, "R9 strobe low in reset", int'(ks_valid), 0);
    // R9: after reset all registers hold 1 and the first pick is pending.
    rst_n = 1'b1;
    model_seed(LA'(1), LB'(1), LC'(1));
    run_rounds(8, 1'b1);

    for (int v = 0; v < NV; v++) begin
      seed_a  = VEC[v][32:25];
      seed_b  = VEC[v][24:18];
      seed_c  = VEC[v][17:13];
      win_b   = VEC[v][12:7];
      win_c   = VEC[v][6:1];
      mix_ctl = VEC[v][0];
      seed_load = 1'b1;
      @(negedge clk);
      chk(ks_valid == 1'b0, "R8 strobe low during load", int'(ks_valid), 0);
      seed_load = 1'b0;
      model_seed(seed_a, seed_b, seed_c);
      run_rounds(12, v == 1);
    end

    // R8: load wins over a low enable.
    en = 1'b0;
    seed_a = 8'hC5; seed_b = 7'h2B; seed_c = 5'h06;
    win_b = {3'd2, 3'd0}; win_c = {3'd6, 3'd3}; mix_ctl = 1'b0;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    en = 1'b1;
    model_seed(seed_a, seed_b, seed_c);
    run_rounds(10, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule